// File: doc/BRIEF.md
# Background Multiply/Divide Unit with HI/LO Interlock

This block is an iterative integer multiply and divide engine for an in-order, five-stage pipeline. Execute hands it one operation with two 32-bit operands. The unit then works on its own for a fixed number of cycles while the pipeline keeps retiring unrelated instructions. When it finishes, it writes its results into two dedicated result registers, HI and LO. No general-purpose register is ever written, so the unit needs no connection to the operand forwarding network.

Multiplication is shift-and-add. Division is restoring. Both run on operand magnitudes, and the signs are applied on the final step. Decode tells the unit what the instruction sitting in decode needs: whether it reads HI or LO, and whether it wants to start another multiply or divide. While the unit is busy, either of these raises a stall. Every other instruction flows past unhindered.

Top module: `muldiv_unit`

## Requirements
- R1: An operation is accepted on a rising clock edge where `issueValid` is high and `busy` is low. `issueOp` selects the operation: 2'b00 is unsigned multiply, 2'b01 is signed multiply, 2'b10 is unsigned divide and 2'b11 is signed divide (bit 1 selects divide, bit 0 selects signed).
- R2: `busy` rises in the cycle after an accepted issue and stays high for exactly 32 cycles. HI and LO take their new values on the same edge that clears `busy`.
- R3: For a multiply, HI holds the upper 32 bits and LO holds the lower 32 bits of the 64-bit product. For the signed variant the operands and the product are two's complement.
- R4: For a divide, LO holds the quotient and HI holds the remainder. Signed division truncates toward zero, and the remainder carries the sign of the dividend. The case -2^31 / -1 yields quotient 32'h80000000 and remainder 0.
- R5: A divide by a zero divisor takes the normal 32 cycles. It leaves LO at all ones and HI equal to the dividend, for both signed and unsigned variants.
- R6: `hiOut` and `loOut` keep their values on every edge except the one that completes an operation.
- R7: `stallDecode` is high exactly when `busy` is high and at least one of `decodeReadsHiLo` or `decodeIsMulDiv` is high.
- R8: An `issueValid` pulse while `busy` is high is ignored. It changes neither the running operation's result nor its completion cycle.
- R9: After reset, `busy` and `stallDecode` are low and HI and LO are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Request to start an operation |
| issueOp | input | 2 | Operation select (see R1) |
| opA | input | 32 | Multiplicand or dividend |
| opB | input | 32 | Multiplier or divisor |
| decodeReadsHiLo | input | 1 | Instruction in decode reads HI or LO |
| decodeIsMulDiv | input | 1 | Instruction in decode starts a multiply or divide |
| stallDecode | output | 1 | Hold the decode stage |
| busy | output | 1 | An operation is in flight |
| hiOut | output | 32 | HI result register |
| loOut | output | 32 | LO result register |

## Verification
Several properties are checked on every cycle:
- `busy` only rises after an issue request.
- `busy` holds until the final step.
- No operation is accepted while busy.
- HI and LO stay frozen except on a completing edge.
- A zero divisor forces LO to all ones.
- The stall output tracks `busy` and the two decode hints.

Numerical correctness across signs, overflow corners and zero divisors can only come from the bench's scenarios. The same is true of the exact 32-cycle latency and of ignored mid-flight issues. The bench compares all of these against a behavioural model.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_DIVU = 2'b10,
    OP_DIVS = 2'b11
  } mdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture operands this edge
    logic step;      // run one iteration this edge
    logic last;      // this iteration is the final one
    logic isDiv;     // divide (else multiply)
    logic isSigned;  // signed variant
  } mdStrobe_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      issueValid,
  input  logic [1:0] issueOp,
  output logic      busy,
  output mdStrobe_t strb
);

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(STEPS - 1);

  logic          busyQ;
  logic [CW-1:0] stepCnt;
  mdOp_e         opQ;
  logic          accept;
  logic          lastStep;

  assign accept   = issueValid && !busyQ;
  assign lastStep = busyQ && (stepCnt == LAST_STEP);

  always_comb begin
    strb.load     = accept;
    strb.step     = busyQ;
    strb.last     = lastStep;
    strb.isDiv    = accept ? issueOp[1] : opQ[1];
    strb.isSigned = accept ? issueOp[0] : opQ[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      stepCnt <= '0;
      opQ     <= OP_MULU;
    end else if (accept) begin
      busyQ   <= 1'b1;
      stepCnt <= '0;
      opQ     <= mdOp_e'(issueOp);
    end else if (busyQ) begin
      if (lastStep) busyQ <= 1'b0;
      else          stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = busyQ;

  // R2: busy only starts after a request
  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(issueValid));

  // R2: busy persists until the final iteration
  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !lastStep) |=> busyQ);

  // R8: no new load while an operation runs
  assert_ignore_issue_R8: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !strb.load);

endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdStrobe_t        strb,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);

  localparam int MSB = WIDTH - 1;

  // working state
  logic [WIDTH-1:0] accQ;    // product upper half / partial remainder
  logic [WIDTH-1:0] lowQ;    // multiplier bits / dividend shifting into quotient
  logic [WIDTH-1:0] opndQ;   // multiplicand / divisor magnitude
  logic             negLoQ;  // negate product or quotient
  logic             negHiQ;  // negate remainder
  logic             divZeroQ;
  logic [WIDTH-1:0] hiQ, loQ;

  // operand magnitudes at load
  logic             signA, signB;
  logic [WIDTH-1:0] magA, magB;

  always_comb begin
    signA = strb.isSigned && opA[MSB];
    signB = strb.isSigned && opB[MSB];
    magA  = signA ? (~opA + 1'b1) : opA;
    magB  = signB ? (~opB + 1'b1) : opB;
  end

  // one multiply iteration
  logic [WIDTH:0]   mulSum;
  logic [WIDTH-1:0] mulAccNext, mulLowNext;

  always_comb begin
    mulSum     = {1'b0, accQ} + (lowQ[0] ? {1'b0, opndQ} : {(WIDTH+1){1'b0}});
    mulAccNext = mulSum[WIDTH:1];
    mulLowNext = {mulSum[0], lowQ[WIDTH-1:1]};
  end

  // one restoring-divide iteration
  logic [WIDTH:0]   divShift, divDiff;
  logic             divFits;
  logic [WIDTH-1:0] divAccNext, divLowNext;

  always_comb begin
    divShift   = {accQ, lowQ[MSB]};
    divDiff    = divShift - {1'b0, opndQ};
    divFits    = !divDiff[WIDTH];
    divAccNext = divFits ? divDiff[WIDTH-1:0] : divShift[WIDTH-1:0];
    divLowNext = {lowQ[WIDTH-2:0], divFits};
  end

  logic [WIDTH-1:0] accNext, lowNext;
  assign accNext = strb.isDiv ? divAccNext : mulAccNext;
  assign lowNext = strb.isDiv ? divLowNext : mulLowNext;

  // sign correction on the final step
  logic [2*WIDTH-1:0] prodMag, prodFinal;
  logic [WIDTH-1:0]   quotFinal, remFinal;
  logic [WIDTH-1:0]   hiFinal, loFinal;

  always_comb begin
    prodMag   = {accNext, lowNext};
    prodFinal = negLoQ ? (~prodMag + 1'b1) : prodMag;
    quotFinal = divZeroQ ? {WIDTH{1'b1}}
                         : (negLoQ ? (~lowNext + 1'b1) : lowNext);
    remFinal  = negHiQ ? (~accNext + 1'b1) : accNext;
    if (strb.isDiv) begin
      hiFinal = remFinal;
      loFinal = quotFinal;
    end else begin
      hiFinal = prodFinal[2*WIDTH-1:WIDTH];
      loFinal = prodFinal[WIDTH-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ     <= '0;
      lowQ     <= '0;
      opndQ    <= '0;
      negLoQ   <= 1'b0;
      negHiQ   <= 1'b0;
      divZeroQ <= 1'b0;
      hiQ      <= '0;
      loQ      <= '0;
    end else if (strb.load) begin
      accQ     <= '0;
      lowQ     <= magA;
      opndQ    <= magB;
      negLoQ   <= signA ^ signB;
      negHiQ   <= strb.isDiv && signA;
      divZeroQ <= strb.isDiv && (opB == '0);
    end else if (strb.step) begin
      accQ <= accNext;
      lowQ <= lowNext;
      if (strb.last) begin
        hiQ <= hiFinal;
        loQ <= loFinal;
      end
    end
  end

  assign hi = hiQ;
  assign lo = loQ;

  // R6: result registers move only on the completing edge
  assert_hilo_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.last |=> ($stable(hiQ) && $stable(loQ)));

  // R5: zero divisor gives an all-ones quotient
  assert_divzero_lo_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.last && strb.isDiv && divZeroQ) |=> (loQ == {WIDTH{1'b1}}));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [1:0]       issueOp,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             decodeReadsHiLo,
  input  logic             decodeIsMulDiv,
  output logic             stallDecode,
  output logic             busy,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);

  mdStrobe_t strb;
  logic      busyInt;

  muldiv_ctrl #(.STEPS(WIDTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issueOp    (issueOp),
    .busy       (busyInt),
    .strb       (strb)
  );

  muldiv_dp #(.WIDTH(WIDTH)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .opA  (opA),
    .opB  (opB),
    .hi   (hiOut),
    .lo   (loOut)
  );

  assign busy        = busyInt;
  assign stallDecode = busyInt && (decodeReadsHiLo || decodeIsMulDiv);

  // R7: a dependent instruction is held while busy
  assert_stall_on_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busyInt && decodeReadsHiLo) |-> stallDecode);

  // R7: never stall while idle
  assert_stall_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busyInt |-> !stallDecode);

endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [1:0]  issueOp = 2'b00;
  logic [31:0] opA = '0, opB = '0;
  logic        decodeReadsHiLo = 1'b0, decodeIsMulDiv = 1'b0;
  logic        stallDecode, busy;
  logic [31:0] hiOut, loOut;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  muldiv_unit u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(issueOp),
    .opA(opA), .opB(opB), .decodeReadsHiLo(decodeReadsHiLo),
    .decodeIsMulDiv(decodeIsMulDiv), .stallDecode(stallDecode),
    .busy(busy), .hiOut(hiOut), .loOut(loOut)
  );

  // behavioural expected result
  function automatic void expect_result(input logic [1:0] op, input logic [31:0] a,
                                        input logic [31:0] b,
                                        output logic [31:0] eh, output logic [31:0] el);
    longint sa, sb, q, r;
    logic [63:0] p;
    case (op)
      2'b00: begin p = {32'b0, a} * {32'b0, b}; eh = p[63:32]; el = p[31:0]; end
      2'b01: begin
        sa = longint'($signed(a)); sb = longint'($signed(b));
        p = 64'(sa * sb); eh = p[63:32]; el = p[31:0];
      end
      default: begin
        if (b == 0) begin el = 32'hFFFF_FFFF; eh = a; end
        else if (op == 2'b10) begin el = a / b; eh = a % b; end
        else begin
          sa = longint'($signed(a)); sb = longint'($signed(b));
          q = sa / sb; r = sa % sb;
          el = q[31:0]; eh = r[31:0];
        end
      end
    endcase
  endfunction

  // cycle reference model
  bit          refBusy;
  int          refCnt;
  logic [31:0] refHi, refLo, pendHi, pendLo;

  always @(posedge clk) begin
    logic [31:0] th, tl;
    if (!rstN) begin
      refBusy <= 0; refCnt <= 0; refHi <= '0; refLo <= '0;
    end else if (refBusy) begin
      if (refCnt + 1 == 32) begin
        refBusy <= 0; refHi <= pendHi; refLo <= pendLo;
      end
      refCnt <= refCnt + 1;
    end else if (issueValid) begin
      expect_result(issueOp, opA, opB, th, tl);
      pendHi <= th; pendLo <= tl; refBusy <= 1; refCnt <= 0;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      vectors++;
      if (busy !== refBusy) begin
        miscompares++; $display("FAIL R2 busy act=%0b exp=%0b", busy, refBusy);
      end
      if (stallDecode !== (refBusy && (decodeReadsHiLo || decodeIsMulDiv))) begin
        miscompares++;
        $display("FAIL R7 stallDecode act=%0b exp=%0b", stallDecode,
                 refBusy && (decodeReadsHiLo || decodeIsMulDiv));
      end
      if (hiOut !== refHi || loOut !== refLo) begin
        miscompares++;
        $display("FAIL R6 hi/lo act=%h/%h exp=%h/%h", hiOut, loOut, refHi, refLo);
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        input string tag, input bit poke);
    logic [31:0] eh, el;
    int n;
    expect_result(op, a, b, eh, el);
    @(negedge clk); #2;
    issueValid = 1; issueOp = op; opA = a; opB = b;
    @(negedge clk); #2;
    issueValid = 0; opA = $urandom; opB = $urandom;
    n = 0;
    while (busy && n < 100) begin
      n++;
      // R8: a second request mid-flight must be ignored
      issueValid = poke && (n == 5 || n == 32);
      issueOp = ~op;
      decodeReadsHiLo = 1'($urandom);
      decodeIsMulDiv = 1'($urandom);
      @(negedge clk); #2;
    end
    issueValid = 0; decodeReadsHiLo = 0; decodeIsMulDiv = 0;
    check({tag, " latency (R2)"}, 64'(n), 64'd32);
    check(tag, {hiOut, loOut}, {eh, el});
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog act=timeout exp=done");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rstN = 1;
    @(negedge clk); #2;
    // R9 reset state
    check("R9 reset busy/stall", {62'b0, busy, stallDecode}, 64'd0);
    check("R9 reset hi/lo", {hiOut, loOut}, 64'd0);
    decodeReadsHiLo = 1; decodeIsMulDiv = 1; #1;
    check("R7 idle no stall", {63'b0, stallDecode}, 64'd0);
    decodeReadsHiLo = 0; decodeIsMulDiv = 0;

    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 R1 mulu max", 0);
    run_op(2'b01, -32'sd3, 32'd7, "R3 R1 muls neg", 0);
    run_op(2'b01, 32'h8000_0000, 32'h8000_0000, "R3 muls minmin", 1);
    run_op(2'b10, 32'd100, 32'd7, "R4 R1 divu", 0);
    run_op(2'b11, -32'sd7, 32'd2, "R4 R1 divs neg dividend", 0);
    run_op(2'b11, 32'd7, -32'sd2, "R4 divs neg divisor", 1);
    run_op(2'b11, 32'h8000_0000, 32'hFFFF_FFFF, "R4 divs overflow", 0);
    run_op(2'b10, 32'd5, 32'd0, "R5 divu by zero", 0);
    run_op(2'b11, -32'sd5, 32'd0, "R5 divs by zero", 1);
    run_op(2'b10, 32'hFFFF_FFFF, 32'd1, "R4 divu by one", 0);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = (i % 7 == 0) ? 32'd0 : ((i % 3 == 0) ? 32'($urandom_range(1, 50)) : $urandom);
      run_op(2'($urandom), ra, rb, "R3 R4 R8 random", 1'($urandom));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule